// File: doc/BRIEF.md
# Real-Time-Clock Transfer Monitor on a Decoded I2C Event Stream

This block listens, without ever driving anything, to a stream of I2C bus events that an upstream bit-level decoder has already produced. Each event is presented for one cycle with a kind code, the byte it carries and the acknowledge state of that byte. The monitor follows write transfers and combined write-then-read transfers aimed at a real-time-clock device. It keeps a register pointer for the transfer and, for every date or time register touched, stores the binary value decoded from the masked BCD byte.

When a tracked transfer closes with a stop, the monitor raises a one-cycle summary pulse and says whether the transfer was a write or a read. It also presents a mask of the fields that the transfer refreshed. Fields that the transfer did not reach keep their earlier values. Bus sampling of SCL and SDA, text formatting and any display all belong elsewhere.

Top module: `rtc_bus_watch`

## Requirements
- R1: After reset, `sum_valid`, `sum_is_read`, `fld_valid`, `volt_low`, `century` and every time field output are zero.
- R2: Event codes are START=0, REPEATED START=1, STOP=2, ADDRESS-WRITE=3, ADDRESS-READ=4, DATA-WRITE=5 and DATA-READ=6. A START, then ADDRESS-WRITE with byte 0xA2, then a DATA-WRITE that sets the pointer, then DATA-WRITE bytes and a STOP, makes `sum_valid` high for exactly one cycle, on the cycle after the STOP event, with `sum_is_read`=0.
- R3: The first DATA-WRITE after the address sets the register pointer. Each accepted data byte, written or read, goes to the register the pointer names, and the pointer then steps up by one.
- R4: A REPEATED START during write data, then ADDRESS-READ with byte 0xA3, then DATA-READ bytes, stores the read bytes from the current pointer onward. The STOP then gives the summary pulse with `sum_is_read`=1.
- R5: The stored value is (low nibble) + 10*(high nibble) of the masked byte. The masks are: register 0x02 seconds 0x7F, with `volt_low` taken from bit 7; 0x03 minutes 0x7F; 0x04 hours 0x3F; 0x05 day 0x3F; 0x06 weekday 0x07; 0x07 month 0x1F, with `century` taken from bit 7; 0x08 year 0xFF.
- R6: An ADDRESS-WRITE byte other than 0xA2, or an ADDRESS-READ byte other than 0xA3, in the address phase returns the monitor to idle. Later data bytes are not stored, and the STOP gives no summary.
- R7: Events that the current phase does not expect change nothing. A START restarts the sequence at the address phase from any state.
- R8: A data byte with `ev_nack`=1 is not stored and does not move the pointer. Later data bytes of that transfer are ignored, and its STOP still gives the summary pulse.
- R9: `fld_valid` bit i is 1 when register 0x02+i was stored during the current transfer. Every START clears it. Fields that were not stored keep their previous values.
- R10: Bytes at register addresses outside 0x02..0x08 change no field and no `fld_valid` bit, but they still advance the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | One decoded bus event is present this cycle |
| ev_kind | input | 3 | Event code (see R2) |
| ev_byte | input | 8 | Address or data byte carried by the event |
| ev_nack | input | 1 | Data byte was not acknowledged |
| sum_valid | output | 1 | One-cycle pulse when a tracked transfer closes |
| sum_is_read | output | 1 | Direction of the last summarised transfer, 1 = read |
| fld_valid | output | 7 | Fields stored in this transfer, bit 0 = seconds .. bit 6 = year |
| t_sec | output | 8 | Seconds, binary |
| t_min | output | 8 | Minutes, binary |
| t_hour | output | 8 | Hours, binary |
| t_day | output | 8 | Day of month, binary |
| t_wday | output | 8 | Weekday, binary |
| t_month | output | 8 | Month, binary |
| t_year | output | 8 | Year within century, binary |
| volt_low | output | 1 | Voltage-low flag from the seconds register |
| century | output | 1 | Century flag from the month register |

## Verification
The assertions assume that at most one event arrives per cycle, that `ev_kind` holds only the seven defined codes while `ev_valid` is high, and that a START never shares a cycle with a data byte. The pointer and halt properties also assume that `ev_nack` matters only on data events. The stimulus drives inputs only at the falling clock edge, one event per cycle, and uses only defined codes. It covers ordinary transfers, wrong device addresses, out-of-phase events, restarts partway through a transfer, refused bytes in both directions, and pointers that start outside the time-field window.

// File: rtl/rtc_mon_pkg.sv
package rtc_mon_pkg;

  localparam int FIELD_CNT  = 7;
  localparam int VL_FIELD   = 0;
  localparam int CENT_FIELD = 5;

  localparam logic [2:0] EV_START   = 3'd0;
  localparam logic [2:0] EV_RSTART  = 3'd1;
  localparam logic [2:0] EV_STOP    = 3'd2;
  localparam logic [2:0] EV_ADDR_WR = 3'd3;
  localparam logic [2:0] EV_ADDR_RD = 3'd4;
  localparam logic [2:0] EV_DATA_WR = 3'd5;
  localparam logic [2:0] EV_DATA_RD = 3'd6;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_AW, S_WAIT_PTR, S_WR_DATA, S_WAIT_AR, S_RD_DATA, S_HALT
  } mon_state_t;

  // Mask applied to each field before BCD conversion, by field index.
  function automatic logic [7:0] fld_mask(input int idx);
    case (idx)
      0, 1:    return 8'h7F;
      2, 3:    return 8'h3F;
      4:       return 8'h07;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
    return {4'd0, b[3:0]} + 8'(b[7:4]) * 8'd10;
  endfunction

endpackage

// File: rtl/rtc_mon_fsm.sv
module rtc_mon_fsm
  import rtc_mon_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h51
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_valid,
  input  logic [2:0] ev_kind,
  input  logic [7:0] ev_byte,
  input  logic       ev_nack,
  output logic       store_o,
  output logic [7:0] store_addr_o,
  output logic       clr_o,
  output logic       done_o,
  output logic       done_rd_o
);

  localparam logic [7:0] WR_ADDR = {DEV_ADDR, 1'b0};
  localparam logic [7:0] RD_ADDR = {DEV_ADDR, 1'b1};

  mon_state_t st_q, st_d;
  logic [7:0] ptr_q, ptr_d;
  logic       rd_q, rd_d;
  logic       done_q, done_d;
  logic       drd_q, drd_d;

  always_comb begin
    st_d    = st_q;
    ptr_d   = ptr_q;
    rd_d    = rd_q;
    done_d  = 1'b0;
    drd_d   = drd_q;
    store_o = 1'b0;
    clr_o   = 1'b0;
    if (ev_valid) begin
      if (ev_kind == EV_START) begin
        st_d  = S_WAIT_AW;
        clr_o = 1'b1;
      end else begin
        case (st_q)
          S_WAIT_AW:
            if (ev_kind == EV_ADDR_WR)
              st_d = (ev_byte == WR_ADDR) ? S_WAIT_PTR : S_IDLE;
          S_WAIT_PTR:
            if (ev_kind == EV_DATA_WR) begin
              rd_d = 1'b0;
              if (ev_nack) st_d = S_HALT;
              else begin
                ptr_d = ev_byte;
                st_d  = S_WR_DATA;
              end
            end
          S_WR_DATA:
            if (ev_kind == EV_RSTART) st_d = S_WAIT_AR;
            else if (ev_kind == EV_STOP) begin
              done_d = 1'b1;
              drd_d  = rd_q;
              st_d   = S_IDLE;
            end else if (ev_kind == EV_DATA_WR) begin
              if (ev_nack) st_d = S_HALT;
              else begin
                store_o = 1'b1;
                ptr_d   = ptr_q + 8'd1;
              end
            end
          S_WAIT_AR:
            if (ev_kind == EV_ADDR_RD) begin
              rd_d = 1'b1;
              st_d = (ev_byte == RD_ADDR) ? S_RD_DATA : S_IDLE;
            end
          S_RD_DATA:
            if (ev_kind == EV_STOP) begin
              done_d = 1'b1;
              drd_d  = rd_q;
              st_d   = S_IDLE;
            end else if (ev_kind == EV_DATA_RD) begin
              if (ev_nack) st_d = S_HALT;
              else begin
                store_o = 1'b1;
                ptr_d   = ptr_q + 8'd1;
              end
            end
          S_HALT:
            if (ev_kind == EV_STOP) begin
              done_d = 1'b1;
              drd_d  = rd_q;
              st_d   = S_IDLE;
            end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ptr_q  <= 8'd0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
      drd_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      rd_q   <= rd_d;
      done_q <= done_d;
      drd_q  <= drd_d;
    end
  end

  assign store_addr_o = ptr_q;
  assign done_o       = done_q;
  assign done_rd_o    = drd_q;

  logic data_nack;
  assign data_nack = ev_valid && ev_nack &&
                     ((st_q == S_WR_DATA && ev_kind == EV_DATA_WR) ||
                      (st_q == S_RD_DATA && ev_kind == EV_DATA_RD));

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R2

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    store_o |=> ptr_q == $past(ptr_q) + 8'd1); // R3

  AST_NACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    data_nack |=> $stable(ptr_q) && st_q == S_HALT); // R8

  AST_BAD_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && st_q == S_WAIT_AW && ev_kind == EV_ADDR_WR && ev_byte != WR_ADDR)
    |=> st_q == S_IDLE); // R6

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == EV_START) |=> st_q == S_WAIT_AW && !done_q); // R7

endmodule

// File: rtl/rtc_mon_fields.sv
module rtc_mon_fields
  import rtc_mon_pkg::*;
#(
  parameter logic [7:0] MAP_BASE = 8'h02
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_i,
  input  logic                          wr_i,
  input  logic [7:0]                    addr_i,
  input  logic [7:0]                    data_i,
  output logic [FIELD_CNT-1:0][7:0]     fld_o,
  output logic [FIELD_CNT-1:0]          valid_o,
  output logic                          vlow_o,
  output logic                          cent_o
);

  localparam logic [7:0] MAP_END = MAP_BASE + 8'(FIELD_CNT);

  logic [FIELD_CNT-1:0] hit;
  logic [FIELD_CNT-1:0] valid_q, valid_d;
  logic                 vlow_q, cent_q;

  for (genvar i = 0; i < FIELD_CNT; i++) begin : g_fld
    localparam logic [7:0] REG_ADDR = MAP_BASE + 8'(i);
    localparam logic [7:0] MASK     = fld_mask(i);
    logic [7:0] val_q;

    assign hit[i] = wr_i && (addr_i == REG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_q <= 8'd0;
      else if (hit[i]) val_q <= bcd_to_bin(data_i & MASK);
    end

    assign fld_o[i] = val_q;
  end

  always_comb begin
    valid_d = valid_q;
    if (clr_i) valid_d = '0;
    else       valid_d = valid_q | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      vlow_q  <= 1'b0;
      cent_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (hit[VL_FIELD])   vlow_q <= data_i[7];
      if (hit[CENT_FIELD]) cent_q <= data_i[7];
    end
  end

  assign valid_o = valid_q;
  assign vlow_o  = vlow_q;
  assign cent_o  = cent_q;

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> valid_q == '0); // R9

  AST_OUT_OF_MAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !clr_i && (addr_i < MAP_BASE || addr_i >= MAP_END))
    |=> $stable(valid_q) && $stable(fld_o)); // R10

  AST_STORE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !clr_i && addr_i >= MAP_BASE && addr_i < MAP_END)
    |=> $countones(valid_q) >= 1); // R9

endmodule

// File: rtl/rtc_bus_watch.sv
module rtc_bus_watch
  import rtc_mon_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h51,
  parameter logic [7:0] MAP_BASE = 8'h02
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_valid,
  input  logic [2:0] ev_kind,
  input  logic [7:0] ev_byte,
  input  logic       ev_nack,
  output logic       sum_valid,
  output logic       sum_is_read,
  output logic [6:0] fld_valid,
  output logic [7:0] t_sec,
  output logic [7:0] t_min,
  output logic [7:0] t_hour,
  output logic [7:0] t_day,
  output logic [7:0] t_wday,
  output logic [7:0] t_month,
  output logic [7:0] t_year,
  output logic       volt_low,
  output logic       century
);

  logic                      store;
  logic [7:0]                store_addr;
  logic                      clr;
  logic [FIELD_CNT-1:0][7:0] fld;

  rtc_mon_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_valid     (ev_valid),
    .ev_kind      (ev_kind),
    .ev_byte      (ev_byte),
    .ev_nack      (ev_nack),
    .store_o      (store),
    .store_addr_o (store_addr),
    .clr_o        (clr),
    .done_o       (sum_valid),
    .done_rd_o    (sum_is_read)
  );

  rtc_mon_fields #(.MAP_BASE(MAP_BASE)) u_fields (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr),
    .wr_i    (store),
    .addr_i  (store_addr),
    .data_i  (ev_byte),
    .fld_o   (fld),
    .valid_o (fld_valid),
    .vlow_o  (volt_low),
    .cent_o  (century)
  );

  assign t_sec   = fld[0];
  assign t_min   = fld[1];
  assign t_hour  = fld[2];
  assign t_day   = fld[3];
  assign t_wday  = fld[4];
  assign t_month = fld[5];
  assign t_year  = fld[6];

endmodule

// File: tb/tb_rtc_bus_watch.sv
module tb_rtc_bus_watch;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ev_valid;
  logic [2:0] ev_kind;
  logic [7:0] ev_byte;
  logic       ev_nack;
  logic       sum_valid, sum_is_read, volt_low, century;
  logic [6:0] fld_valid;
  logic [7:0] t_sec, t_min, t_hour, t_day, t_wday, t_month, t_year;

  always #4 clk = ~clk;

  rtc_bus_watch dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_byte(ev_byte), .ev_nack(ev_nack), .sum_valid(sum_valid),
    .sum_is_read(sum_is_read), .fld_valid(fld_valid), .t_sec(t_sec),
    .t_min(t_min), .t_hour(t_hour), .t_day(t_day), .t_wday(t_wday),
    .t_month(t_month), .t_year(t_year), .volt_low(volt_low), .century(century)
  );

  localparam logic [2:0] ST = 3'd0, RS = 3'd1, SP = 3'd2, AW = 3'd3,
                         AR = 3'd4, DW = 3'd5, DR = 3'd6;

  // {kind, byte, nack, expected sum_valid, expected sum_is_read}
  localparam int NV = 19;
  localparam logic [13:0] VEC [NV] = '{
    {ST, 8'h00, 1'b0, 1'b0, 1'b0},
    {AW, 8'hA2, 1'b0, 1'b0, 1'b0},
    {DW, 8'h02, 1'b0, 1'b0, 1'b0},
    {DW, 8'h59, 1'b0, 1'b0, 1'b0},
    {DW, 8'h45, 1'b0, 1'b0, 1'b0},
    {DW, 8'h23, 1'b0, 1'b0, 1'b0},
    {DW, 8'h31, 1'b0, 1'b0, 1'b0},
    {DW, 8'h05, 1'b0, 1'b0, 1'b0},
    {DW, 8'h92, 1'b0, 1'b0, 1'b0},
    {DW, 8'h99, 1'b0, 1'b0, 1'b0},
    {SP, 8'h00, 1'b0, 1'b1, 1'b0},
    {ST, 8'h00, 1'b0, 1'b0, 1'b0},
    {AW, 8'hA2, 1'b0, 1'b0, 1'b0},
    {DW, 8'h04, 1'b0, 1'b0, 1'b0},
    {RS, 8'h00, 1'b0, 1'b0, 1'b0},
    {AR, 8'hA3, 1'b0, 1'b0, 1'b0},
    {DR, 8'h12, 1'b0, 1'b0, 1'b0},
    {DR, 8'h07, 1'b0, 1'b0, 1'b0},
    {SP, 8'h00, 1'b0, 1'b1, 1'b1}
  };

  int  n_chk = 0;
  int  n_err = 0;
  bit  finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [7:0] b, input logic n);
    ev_valid = 1'b1; ev_kind = k; ev_byte = b; ev_nack = n;
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0; ev_nack = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ev_valid = 1'b0; ev_kind = 3'd0; ev_byte = 8'd0; ev_nack = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sum_valid", sum_valid, 0);
    chk("R1 sum_is_read", sum_is_read, 0);
    chk("R1 fld_valid", fld_valid, 0);
    chk("R1 t_sec", t_sec, 0);
    chk("R1 t_year", t_year, 0);
    chk("R1 flags", {volt_low, century}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: full write, then combined read from register 0x04
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][13:11], VEC[i][10:3], VEC[i][2]);
      chk("R2/R4 sum_valid", sum_valid, VEC[i][1]);
      if (VEC[i][1]) chk("R2/R4 sum_is_read", sum_is_read, VEC[i][0]);
    end
    chk("R3 sec", t_sec, 59);
    chk("R3 min", t_min, 45);
    chk("R5 month", t_month, 12);
    chk("R5 century", century, 1);
    chk("R5 year", t_year, 99);
    chk("R5 wday", t_wday, 5);
    chk("R4 hour", t_hour, 12);
    chk("R4 day", t_day, 7);
    chk("R9 read mask", fld_valid, 7'h0C);
    @(negedge clk);
    chk("R2 pulse one cycle", sum_valid, 0);

    // R5 masks and flags
    send(ST, 0, 0); send(AW, 8'hA2, 0); send(DW, 8'h02, 0);
    send(DW, 8'hD3, 0); send(DW, 8'h80, 0); send(DW, 8'hE5, 0);
    send(DW, 8'hC8, 0); send(DW, 8'hFE, 0); send(DW, 8'h71, 0);
    send(SP, 0, 0);
    chk("R5 sec", t_sec, 53);
    chk("R5 volt_low", volt_low, 1);
    chk("R5 min", t_min, 0);
    chk("R5 hour", t_hour, 25);
    chk("R5 day", t_day, 8);
    chk("R5 wday", t_wday, 6);
    chk("R5 month", t_month, 11);
    chk("R5 century", century, 0);
    chk("R9 year kept", t_year, 99);
    chk("R9 mask", fld_valid, 7'h3F);

    // R6 wrong write address
    send(ST, 0, 0); send(AW, 8'hA0, 0); send(DW, 8'h02, 0); send(DW, 8'h11, 0);
    send(SP, 0, 0);
    chk("R6 no summary write", sum_valid, 0);
    chk("R6 sec kept", t_sec, 53);
    // R6 wrong read address
    send(ST, 0, 0); send(AW, 8'hA2, 0); send(DW, 8'h02, 0); send(RS, 0, 0);
    send(AR, 8'hA5, 0); send(DR, 8'h44, 0); send(SP, 0, 0);
    chk("R6 no summary read", sum_valid, 0);
    chk("R6 sec kept read", t_sec, 53);

    // R7 out-of-phase event ignored
    send(ST, 0, 0); send(AW, 8'hA2, 0); send(DW, 8'h02, 0);
    send(DR, 8'h11, 0);
    chk("R7 read ignored in write", t_sec, 53);
    send(DW, 8'h22, 0); send(SP, 0, 0);
    chk("R7 summary", sum_valid, 1);
    chk("R7 sec", t_sec, 22);

    // R7 START partway through restarts, R9 clears mask
    send(ST, 0, 0); send(AW, 8'hA2, 0); send(DW, 8'h03, 0); send(DW, 8'h10, 0);
    send(ST, 0, 0);
    chk("R9 cleared by start", fld_valid, 0);
    send(AW, 8'hA2, 0); send(DW, 8'h02, 0); send(DW, 8'h33, 0);
    send(SP, 0, 0);
    chk("R7 restart summary", sum_valid, 1);
    chk("R7 sec", t_sec, 33);
    chk("R9 min kept", t_min, 10);
    chk("R9 mask", fld_valid, 7'h01);

    // R8 refused write byte
    send(ST, 0, 0); send(AW, 8'hA2, 0); send(DW, 8'h02, 0); send(DW, 8'h41, 0);
    send(DW, 8'h42, 1);
    send(DW, 8'h43, 0);
    chk("R8 later byte ignored", t_min, 10);
    send(SP, 0, 0);
    chk("R8 summary", sum_valid, 1);
    chk("R8 write dir", sum_is_read, 0);
    chk("R8 sec", t_sec, 41);
    chk("R8 mask", fld_valid, 7'h01);
    // R8 refused read byte
    send(ST, 0, 0); send(AW, 8'hA2, 0); send(DW, 8'h05, 0); send(RS, 0, 0);
    send(AR, 8'hA3, 0); send(DR, 8'h09, 0); send(DR, 8'h04, 1);
    send(SP, 0, 0);
    chk("R8 read summary", {sum_valid, sum_is_read}, 2'b11);
    chk("R8 day", t_day, 9);
    chk("R8 wday kept", t_wday, 6);
    chk("R8 read mask", fld_valid, 7'h08);

    // R10 bytes below and above the field window
    send(ST, 0, 0); send(AW, 8'hA2, 0); send(DW, 8'h00, 0); send(DW, 8'h11, 0);
    send(DW, 8'h22, 0);
    chk("R10 no mask below", fld_valid, 0);
    send(DW, 8'h15, 0); send(SP, 0, 0);
    chk("R10 sec after skip", t_sec, 15);
    chk("R10 mask", fld_valid, 7'h01);
    send(ST, 0, 0); send(AW, 8'hA2, 0); send(DW, 8'h08, 0); send(DW, 8'h20, 0);
    send(DW, 8'h77, 0); send(SP, 0, 0);
    chk("R10 year", t_year, 20);
    chk("R10 mask above", fld_valid, 7'h40);
    chk("R10 sec kept", t_sec, 15);

    // R1 reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R1 year after reset", t_year, 0);
    chk("R1 mask after reset", fld_valid, 0);
    chk("R1 dir after reset", sum_is_read, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule